// File: doc/BRIEF.md
# Periodic Countdown Timer

A 32-bit down-counter with four word registers on a simple word-wide register bus. Software writes a reload value into the period register. It then sets the start bit in the control register. From then on, every pulse on the tick input lowers the live count by one. The live count can be read at any time through a read-only snapshot register.

Control bit 0 has two jobs. When the count is already zero on a tick, it decides whether the count reloads from the period or stays at zero. It also gates the interrupt output, which is high for as long as the count is zero and bit 0 is set.

The tick is a one-cycle enable sampled on the system clock, so the timer can follow a divided clock without a second clock domain. An access that is not allowed changes no register and raises an error flag in the response cycle.

Top module: `cdtimer`

## Requirements
- R1: After reset the status, control, period and count registers all read zero, and irq is low.
- R2: The count changes only on a cycle where tick is high and control bit 2 (start) is set. A tick while bit 2 is clear leaves the count unchanged.
- R3: On a counting tick, a nonzero count decreases by exactly one.
- R4: On a counting tick, a zero count is loaded with the period register when control bit 0 is set, and stays at zero when bit 0 is clear.
- R5: irq is high exactly when the count is zero and control bit 0 is set.
- R6: Each register sits at a byte offset: status 0x00, control 0x04, period 0x08, snapshot (the count) 0x0C. Status, control and period accept a full-word write. A read of any of the four returns its value on rdata in the cycle after rd_en, with err low.
- R7: These accesses are illegal: a write to 0x0C, an access to any other offset outside the four above, and an access whose nbytes is not 4. An illegal access changes no register. It drives err high for the one cycle after the strobe, and an illegal read returns zero.
- R8: A register write takes effect at the clock edge that samples it. A tick in the same cycle as the write uses the old control and period values, so a write that sets the start bit begins counting at the first later tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable |
| rd_en | input | 1 | Read strobe (never together with wr_en) |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Byte offset of the access |
| nbytes | input | 3 | Access size in bytes; only 4 is legal |
| wdata | input | DW | Write data, most significant byte in bits 31:24 |
| rdata | output | DW | Read data, valid the cycle after rd_en |
| err | output | 1 | Illegal-access flag, one cycle after the strobe |
| irq | output | 1 | Interrupt: count is zero and control bit 0 is set |

## Verification
The hardest case to reach is a tick that finds the count at zero, because the outcome depends on control bit 0 and on a period value that may have just been rewritten. A random stream alone rarely gets there with large periods. The random stimulus therefore draws periods from a small range, ticks about half the time, and often rewrites control and period. Directed cases add a write and a tick in the same cycle, a zero period with reload on, and a countdown run to zero with reload off.

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int START_BIT = 2,
  parameter int AUTO_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    nbytes,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_STAT = AW'(0);
  localparam logic [AW-1:0] OFS_CTRL = AW'(4);
  localparam logic [AW-1:0] OFS_PER  = AW'(8);
  localparam logic [AW-1:0] OFS_SNAP = AW'(12);
  localparam logic [2:0]    WORD_BYTES = 3'd4;

  logic [DW-1:0] stat_q, ctrl_q, per_q, cnt_q;
  logic [DW-1:0] rd_mux;

  logic hit_stat, hit_ctrl, hit_per, hit_snap, size_ok;
  logic rd_ok, wr_ok, running, at_zero, auto_rl;

  assign hit_stat = (addr == OFS_STAT);
  assign hit_ctrl = (addr == OFS_CTRL);
  assign hit_per  = (addr == OFS_PER);
  assign hit_snap = (addr == OFS_SNAP);
  assign size_ok  = (nbytes == WORD_BYTES);

  assign wr_ok = wr_en & size_ok & (hit_stat | hit_ctrl | hit_per);
  assign rd_ok = rd_en & size_ok & (hit_stat | hit_ctrl | hit_per | hit_snap);

  assign running = tick & ctrl_q[START_BIT];
  assign at_zero = (cnt_q == '0);
  assign auto_rl = ctrl_q[AUTO_BIT];
  assign irq     = at_zero & auto_rl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ctrl_q <= '0;
      per_q  <= '0;
    end else if (wr_ok) begin
      if (hit_stat) stat_q <= wdata;
      if (hit_ctrl) ctrl_q <= wdata;
      if (hit_per)  per_q  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (running) begin
      if (!at_zero)     cnt_q <= cnt_q - 1'b1;
      else if (auto_rl) cnt_q <= per_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_ok) begin
      unique case (1'b1)
        hit_stat: rd_mux = stat_q;
        hit_ctrl: rd_mux = ctrl_q;
        hit_per:  rd_mux = per_q;
        hit_snap: rd_mux = cnt_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      err <= (rd_en & ~rd_ok) | (wr_en & ~wr_ok);
    end
  end
endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk #(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int START_BIT = 2,
  parameter int AUTO_BIT  = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          err,
  input logic          irq,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] per_q,
  input logic [DW-1:0] cnt_q
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && ctrl_q[START_BIT]) |=> $stable(cnt_q));

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl_q[START_BIT] && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl_q[START_BIT] && cnt_q == '0 && ctrl_q[AUTO_BIT]) |=> (cnt_q == $past(per_q)));

  a_r4_stay_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !ctrl_q[AUTO_BIT]) |=> (cnt_q == '0));

  a_r5_irq_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_q[AUTO_BIT] && cnt_q == '0));

  a_r7_snap_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12)) |=> (err && $stable(stat_q) && $stable(ctrl_q) && $stable(per_q)));

  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_en || wr_en));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
endmodule

bind cdtimer cdtimer_chk #(.DW(DW), .AW(AW), .START_BIT(START_BIT), .AUTO_BIT(AUTO_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .err(err), .irq(irq), .stat_q(stat_q), .ctrl_q(ctrl_q),
  .per_q(per_q), .cnt_q(cnt_q)
);

// File: tb/cdtimer_bench.sv
module cdtimer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [2:0]  nbytes = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, irq;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_stat = 0, m_ctrl = 0, m_per = 0, m_cnt = 0;

  cdtimer u_cdtimer (.clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .nbytes(nbytes), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq));

  always #4 clk = ~clk;

  function automatic bit legal(input logic [7:0] a, input logic [2:0] sz, input bit wr);
    if (sz != 3'd4) return 0;
    if (a == 8'h00 || a == 8'h04 || a == 8'h08) return 1;
    if (a == 8'h0C) return !wr;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return m_stat;
      8'h04: return m_ctrl;
      8'h08: return m_per;
      8'h0C: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] next_cnt(input bit t);
    if (!(t && m_ctrl[2])) return m_cnt;
    if (m_cnt != 0) return m_cnt - 1;
    return m_ctrl[0] ? m_per : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit rd, input bit wr, input logic [7:0] a,
                     input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] exp_rd, nc;
    bit ok;
    tick = t; rd_en = rd; wr_en = wr; addr = a; nbytes = sz; wdata = d;
    ok = legal(a, sz, wr);
    exp_rd = (rd && ok) ? model_read(a) : 32'h0;
    nc = next_cnt(t);
    @(posedge clk);
    @(negedge clk);
    m_cnt = nc;
    if (wr && ok) begin
      if (a == 8'h00) m_stat = d;
      if (a == 8'h04) m_ctrl = d;
      if (a == 8'h08) m_per = d;
    end
    tick = 0; rd_en = 0; wr_en = 0;
    check("R5 irq", {31'b0, irq}, {31'b0, (m_cnt == 0) && m_ctrl[0]});
    if (rd || wr) check(ok ? "R6 err" : "R7 err", {31'b0, err}, {31'b0, !ok});
    if (rd) check(ok ? "R6 rdata" : "R7 rdata", rdata, exp_rd);
  endtask

  task automatic rd_snap(input string req);
    logic [31:0] exp;
    exp = m_cnt;
    cyc(0, 1, 0, 8'h0C, 3'd4, 0);
    check(req, rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a;
    logic [31:0] d;
    bit t, rd, wr;
    logic [2:0] sz;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    cyc(0, 1, 0, 8'h00, 4, 0); check("R1 status", rdata, 0);
    cyc(0, 1, 0, 8'h04, 4, 0); check("R1 control", rdata, 0);
    cyc(0, 1, 0, 8'h08, 4, 0); check("R1 period", rdata, 0);
    cyc(0, 1, 0, 8'h0C, 4, 0); check("R1 count", rdata, 0);
    // R4 reload with zero count, then R3 decrement
    cyc(0, 0, 1, 8'h08, 4, 32'd3);
    cyc(1, 0, 1, 8'h04, 4, 32'h5);          // R8 tick with write uses old control
    rd_snap("R8 same-cycle start");
    cyc(0, 0, 0, 8'h00, 4, 0);
    rd_snap("R2 no tick hold");
    cyc(1, 0, 0, 8'h00, 4, 0);
    rd_snap("R4 reload");
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 0, 8'h00, 4, 0);
      rd_snap("R3 decrement");
    end
    // R2 stopped timer ignores ticks
    cyc(0, 0, 1, 8'h04, 4, 32'h1);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 8'h00, 4, 0);
    rd_snap("R2 stopped");
    // R4 stay at zero without bit 0
    cyc(0, 0, 1, 8'h04, 4, 32'h4);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 8'h00, 4, 0);
    rd_snap("R4 stay zero");
    // R7 illegal accesses
    cyc(0, 0, 1, 8'h0C, 4, 32'hDEAD);
    cyc(0, 0, 1, 8'h10, 4, 32'hBEEF);
    cyc(0, 0, 1, 8'h05, 4, 32'hBEEF);
    cyc(0, 0, 1, 8'h08, 2, 32'hBEEF);
    cyc(0, 1, 0, 8'h08, 1, 0);
    cyc(0, 1, 0, 8'h14, 4, 0);
    cyc(0, 1, 0, 8'h08, 4, 0); check("R7 period kept", rdata, 32'd3);
    cyc(0, 1, 0, 8'h04, 4, 0); check("R7 control kept", rdata, 32'h4);
    // R6 status scratch
    cyc(0, 0, 1, 8'h00, 4, 32'hA5C3_0F12);
    cyc(0, 1, 0, 8'h00, 4, 0); check("R6 status", rdata, 32'hA5C3_0F12);
    // zero period with reload on
    cyc(0, 0, 1, 8'h08, 4, 0);
    cyc(0, 0, 1, 8'h04, 4, 32'h5);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 8'h00, 4, 0);
    rd_snap("R4 zero period");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      t = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: begin rd = 0; wr = 1; end
        1: begin rd = 1; wr = 0; end
        default: begin rd = 0; wr = 0; end
      endcase
      case ($urandom % 8)
        0, 1: a = 8'h04;
        2, 3: a = 8'h08;
        4: a = 8'h0C;
        5: a = 8'h00;
        6: a = 8'($urandom);
        default: a = 8'h0C;
      endcase
      sz = (($urandom % 10) == 0) ? 3'($urandom) : 3'd4;
      d = (a == 8'h08) ? ($urandom % 6) : (a == 8'h04 ? ($urandom % 8) : $urandom);
      cyc(t, rd, wr, a, sz, d);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule